// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible control and status store of a multi-channel DMA engine. Software reaches it through a small memory-mapped bus with separate read and write strobes. It uses the bank to freeze individual channels, to request a reset of a channel, to enable completion interrupts and to acknowledge completion and error flags. The channel sequencers report back with single-cycle pulses. A completion pulse sets that channel's completion flag. An error pulse sets that channel's error flag and records whether the cause was a bus fault or a termination.

Each register sits in a 16-byte slot. The slot has three word addresses. The plain address overwrites the whole register. The set alias ORs the written ones into the register, and the clear alias removes them. Because of the aliases, software can change one channel's bits without a read-modify-write, which would race with hardware events. For each channel the bank drives a freeze level, a one-cycle reset pulse and an interrupt line. It also drives two global burst-enable levels. The bus is a plain register strobe interface with no back-pressure: a write takes effect at the clock edge where it is strobed, and read data is combinational while the read strobe is high.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every register reads 0 and the freeze, reset, interrupt and burst outputs are all low.
- R2: The slot index is address bits [7:4]. Slot 0 (0x00) is global control, with burst enables at bits 28 and 29 and all other bits reading 0. Slot 1 (0x10) is channel control. Slot 2 (0x20) is interrupt. Slot 3 (0x30) is error. Reads of any other slot return 0, and writes to any other slot change nothing.
- R3: Within a slot, offset +0x0 writes the whole register, +0x4 sets the bits written as 1, and +0x8 clears the bits written as 1. A write to offset +0xC, or to an address with bits [1:0] not zero, has no effect.
- R4: Channel-control bits [15:0] are freeze bits, and bit c drives chan_freeze_o[c] as a level.
- R5: Channel-control bits [31:16] are reset requests. Writing a 1 to bit 16+c drives chan_reset_o[c] high for exactly one cycle, after which the bit clears itself. The bit reads back as 1 only during that cycle.
- R6: A pulse on chan_done_i[c] sets interrupt bit c. Interrupt bits [31:16] are the matching enables, and software can write them.
- R7: A pulse on chan_err_i[c] sets error bit c and copies chan_err_bus_i[c] into error bit 16+c (1 = bus error, 0 = termination).
- R8: When a hardware event and a software write or clear hit the same flag bit in the same cycle, the hardware value wins. Other bits of the same access still take effect.
- R9: chan_irq_o[c] equals (completion bit c AND enable bit c) OR error bit c.
- R10: Global-control bits 28 and 29 drive burst_en_o[0] and burst_en_o[1] as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, 0 while the read strobe is low |
| chan_done_i | input | 16 | Per-channel completion pulses |
| chan_err_i | input | 16 | Per-channel error pulses |
| chan_err_bus_i | input | 16 | Error cause qualifier, 1 = bus error |
| chan_freeze_o | output | 16 | Per-channel freeze levels |
| chan_reset_o | output | 16 | Per-channel one-cycle reset pulses |
| chan_irq_o | output | 16 | Per-channel interrupt lines |
| burst_en_o | output | 2 | Burst enable levels |

## Verification
The collision case is a sequencer pulse that lands in the same cycle as a software acknowledge through the clear alias. The bench strobes a clear of two flags on the interrupt register and the error register. In the same cycle it pulses completion or error for one of those two channels. The check passes if, on read-back and on the interrupt lines, the pulsed channel's flag survives and the other channel's flag is gone.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // Alias code equals address bits [3:2]
  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    SLOT_GLB = 2'd0,
    SLOT_CHN = 2'd1,
    SLOT_IRQ = 2'd2,
    SLOT_ERR = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;
  localparam int BURST_LSB = 28;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output csr_op_e           op_o [NUM_SLOTS],
  output logic              slot_hit_o,
  output slot_e             slot_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic    aligned;
  csr_op_e alias_op;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign alias_op   = csr_op_e'(addr_i[3:2]);
  assign slot_hit_o = (addr_i[ADDR_W-1:4] < SLOT_W'(NUM_SLOTS));
  assign slot_o     = slot_e'(addr_i[5:4]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign op_o[s] = (wr_en_i && aligned && slot_hit_o && (slot_o == slot_e'(s)))
                     ? alias_op : OP_NONE;
  end
endmodule

// File: rtl/csr_field.sv
module csr_field
  import dma_csr_pkg::*;
#(
  parameter int W        = 16,
  parameter bit SELF_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  csr_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_mask_i,
  input  logic [W-1:0] hw_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, base, sw_nxt, nxt;

  always_comb begin
    base = SELF_CLR ? '0 : q_r;
    unique case (op_i)
      OP_WR:   sw_nxt = wdata_i;
      OP_SET:  sw_nxt = base | wdata_i;
      OP_CLR:  sw_nxt = base & ~wdata_i;
      default: sw_nxt = base;
    endcase
    nxt = (sw_nxt & ~hw_mask_i) | (hw_val_i & hw_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= nxt;
  end

  assign q_o = q_r;

  // R8: a hardware-driven bit always takes the hardware value
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_mask_i) |=> (((q_r ^ $past(hw_val_i)) & $past(hw_mask_i)) == '0));
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] err_i,
  output logic [NCH-1:0] irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign irq_o[c] = (done_i[c] & en_i[c]) | err_i[c];
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [2*NCH-1:0]  reg_wdata_i,
  output logic [2*NCH-1:0]  reg_rdata_o,
  input  logic [NCH-1:0]    chan_done_i,
  input  logic [NCH-1:0]    chan_err_i,
  input  logic [NCH-1:0]    chan_err_bus_i,
  output logic [NCH-1:0]    chan_freeze_o,
  output logic [NCH-1:0]    chan_reset_o,
  output logic [NCH-1:0]    chan_irq_o,
  output logic [1:0]        burst_en_o
);
  localparam int DW     = 2 * NCH;
  localparam int SLOT_W = ADDR_W - 4;

  csr_op_e op [NUM_SLOTS];
  logic    slot_hit;
  slot_e   slot;

  logic [1:0]     burst_q;
  logic [NCH-1:0] frz_q, rst_q, done_q, en_q, err_q, bus_q;

  csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
    .op_o(op), .slot_hit_o(slot_hit), .slot_o(slot)
  );

  csr_field #(.W(2)) u_burst (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_GLB]),
    .wdata_i(reg_wdata_i[BURST_LSB +: 2]),
    .hw_mask_i('0), .hw_val_i('0), .q_o(burst_q)
  );

  csr_field #(.W(NCH)) u_freeze (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_CHN]),
    .wdata_i(reg_wdata_i[NCH-1:0]),
    .hw_mask_i('0), .hw_val_i('0), .q_o(frz_q)
  );

  csr_field #(.W(NCH), .SELF_CLR(1'b1)) u_reset (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_CHN]),
    .wdata_i(reg_wdata_i[DW-1:NCH]),
    .hw_mask_i('0), .hw_val_i('0), .q_o(rst_q)
  );

  csr_field #(.W(NCH)) u_done (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_IRQ]),
    .wdata_i(reg_wdata_i[NCH-1:0]),
    .hw_mask_i(chan_done_i), .hw_val_i('1), .q_o(done_q)
  );

  csr_field #(.W(NCH)) u_enable (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_IRQ]),
    .wdata_i(reg_wdata_i[DW-1:NCH]),
    .hw_mask_i('0), .hw_val_i('0), .q_o(en_q)
  );

  csr_field #(.W(NCH)) u_err (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_ERR]),
    .wdata_i(reg_wdata_i[NCH-1:0]),
    .hw_mask_i(chan_err_i), .hw_val_i('1), .q_o(err_q)
  );

  csr_field #(.W(NCH)) u_bus (
    .clk(clk), .rst_n(rst_n), .op_i(op[SLOT_ERR]),
    .wdata_i(reg_wdata_i[DW-1:NCH]),
    .hw_mask_i(chan_err_i), .hw_val_i(chan_err_bus_i), .q_o(bus_q)
  );

  csr_irq #(.NCH(NCH)) u_irq (
    .done_i(done_q), .en_i(en_q), .err_i(err_q), .irq_o(chan_irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i && slot_hit) begin
      unique case (slot)
        SLOT_GLB: reg_rdata_o[BURST_LSB +: 2] = burst_q;
        SLOT_CHN: reg_rdata_o = {rst_q, frz_q};
        SLOT_IRQ: reg_rdata_o = {en_q, done_q};
        SLOT_ERR: reg_rdata_o = {bus_q, err_q};
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign chan_freeze_o = frz_q;
  assign chan_reset_o  = rst_q;
  assign burst_en_o    = burst_q;

  // R5: reset request lasts a single cycle
  p_reset_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_reset_o) |=> ((chan_reset_o & $past(chan_reset_o)) == '0));

  // R6: completion pulse is recorded
  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_done_i) |=> ((done_q & $past(chan_done_i)) == $past(chan_done_i)));

  // R7: error pulse sets the flag and records the cause
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_err_i) |=> (((err_q & $past(chan_err_i)) == $past(chan_err_i)) &&
                       (((bus_q ^ $past(chan_err_bus_i)) & $past(chan_err_i)) == '0)));

  // R9: interrupt line follows flags and enables
  p_irq_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq_o == ((done_q & en_q) | err_q));

  // R3: set alias on channel control ORs freeze bits in
  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_addr_i[ADDR_W-1:4] == SLOT_W'(SLOT_CHN)) && (reg_addr_i[3:0] == 4'h4))
    |=> ((chan_freeze_o & $past(reg_wdata_i[NCH-1:0])) == $past(reg_wdata_i[NCH-1:0])));
endmodule

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] done_i = '0, err_i = '0, bus_i = '0;
  logic [15:0] freeze_o, reset_o, irq_o;
  logic [1:0]  burst_o;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  dma_csr_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .chan_done_i(done_i), .chan_err_i(err_i), .chan_err_bus_i(bus_i),
    .chan_freeze_o(freeze_o), .chan_reset_o(reset_o), .chan_irq_o(irq_o),
    .burst_en_o(burst_o)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {8'h10, 32'h0000_00A5, 8'h10, 32'h0000_00A5}, // R2 plain write
    {8'h14, 32'h0000_0100, 8'h10, 32'h0000_01A5}, // R3 set alias
    {8'h18, 32'h0000_0005, 8'h10, 32'h0000_01A0}, // R3 clear alias
    {8'h1C, 32'hFFFF_FFFF, 8'h10, 32'h0000_01A0}, // R3 offset C ignored
    {8'h00, 32'hFFFF_FFFF, 8'h00, 32'h3000_0000}, // R10 burst bits only
    {8'h08, 32'h1000_0000, 8'h00, 32'h2000_0000}, // R10 clear one burst bit
    {8'h20, 32'h00FF_0000, 8'h20, 32'h00FF_0000}, // R6 enables
    {8'h34, 32'h0000_0003, 8'h30, 32'h0000_0003}, // R3 error set
    {8'h38, 32'h0000_0003, 8'h30, 32'h0000_0000}, // R3 error clear
    {8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000}, // R2 unmapped slot
    {8'h11, 32'h0000_FFFF, 8'h10, 32'h0000_01A0}  // R3 misaligned ignored
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [7:0]  wa, ra;
    logic [31:0] wd, ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 freeze", {16'h0, freeze_o}, 32'h0);
    chk("R1 reset",  {16'h0, reset_o},  32'h0);
    chk("R1 irq",    {16'h0, irq_o},    32'h0);
    chk("R1 burst",  {30'h0, burst_o},  32'h0);
    for (int s = 0; s < 4; s++) begin
      rd(8'(s * 16), got);
      chk("R1 register", got, 32'h0);
    end

    // table walk (R2, R3, R6, R10)
    for (int i = 0; i < NV; i++) begin
      {wa, wd, ra, ex} = VEC[i];
      wr(wa, wd);
      rd(ra, got);
      chk($sformatf("R2/R3 vector %0d", i), got, ex);
    end
    chk("R4 freeze out", {16'h0, freeze_o}, 32'h0000_01A0);
    chk("R10 burst out", {30'h0, burst_o}, 32'h2);

    // R5 self-clearing reset pulse
    wr(8'h14, 32'h0003_0000);
    chk("R5 pulse high", {16'h0, reset_o}, 32'h3);
    rd(8'h10, got);
    chk("R5 readback during pulse", got, 32'h0003_01A0);
    step();
    chk("R5 pulse gone", {16'h0, reset_o}, 32'h0);
    rd(8'h10, got);
    chk("R5 readback after", got, 32'h0000_01A0);

    // R6 completion pulses, R9 interrupt lines
    done_i = 16'h0004; step(); done_i = '0;
    rd(8'h20, got);
    chk("R6 done ch2", got, 32'h00FF_0004);
    chk("R9 irq enabled", {16'h0, irq_o}, 32'h0004);
    done_i = 16'h0200; step(); done_i = '0;
    rd(8'h20, got);
    chk("R6 done ch9", got, 32'h00FF_0204);
    chk("R9 irq masked ch9", {16'h0, irq_o}, 32'h0004);

    // R7 error with cause
    err_i = 16'h1800; bus_i = 16'h0800; step(); err_i = '0; bus_i = '0;
    rd(8'h30, got);
    chk("R7 error flags and cause", got, 32'h0800_1800);
    chk("R9 irq with errors", {16'h0, irq_o}, 32'h1804);

    // R8 hardware beats same-cycle clear
    reg_addr = 8'h28; reg_wdata = 32'h0000_0204; reg_wr = 1'b1; done_i = 16'h0004;
    step();
    reg_wr = 1'b0; done_i = '0;
    rd(8'h20, got);
    chk("R8 done survives clear", got, 32'h00FF_0004);
    reg_addr = 8'h38; reg_wdata = 32'h0000_1800; reg_wr = 1'b1; err_i = 16'h1000;
    step();
    reg_wr = 1'b0; err_i = '0;
    rd(8'h30, got);
    chk("R8 error survives clear", got, 32'h0800_1000);
    chk("R8 irq after collision", {16'h0, irq_o}, 32'h1004);

    // R9 all cleared
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0000_FFFF);
    chk("R9 irq cleared", {16'h0, irq_o}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule